// File: doc/BRIEF.md
# Packed Rounding Right-Shift and Accumulate Unit

This block is the datapath for a vector rounding right shift by an immediate. A 128-bit source vector is split into equal lanes of 8, 16, 32 or 64 bits. Every lane is shifted right by the same amount and rounded half-up on the bits that are shifted out. The shift is arithmetic for signed lanes and logical for unsigned lanes. In accumulate mode, each rounded lane is added with wrap-around into the matching lane of the old destination vector.

The operation covers either the low 64 bits or the full 128 bits. Destination bits above the active width always come out as zero. One issuing encoding supplies the count as a negative number, so a control input negates the amount before use. The result is registered. It appears one clock after a cycle with `in_valid` high and holds while `in_valid` stays low.

Top module: `vrshift_acc_unit`

## Requirements
- R1: `lane_sz` picks the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. All lanes of one operation use the same width and the same shift amount, and each lane is computed independently of its neighbours.
- R2: For an unsigned lane x and a shift s (1 <= s <= width), the rounded value is floor((x + 2^(s-1)) / 2^s), taken modulo 2^width.
- R3: For a signed lane, x is read as two's complement and the same formula is used with arithmetic (floor) division, so negative inputs round toward plus infinity on exact halves.
- R4: With `accum_en`=1, the rounded value is added modulo 2^width to the destination lane. No carry passes into the next lane.
- R5: A signed lane shifted by exactly its width gives 0 for any input.
- R6: An unsigned lane shifted by exactly its width gives the lane's most significant bit (0 or 1).
- R7: A signed full-width shift with accumulation returns the destination lane unchanged.
- R8: With `wide_op`=0, only bits 63:0 are processed and result bits 127:64 are zero. This holds in accumulate mode as well.
- R9: With `shift_neg`=1, the 8-bit `shift_amt` is read as a negative two's-complement count and negated before use. For example, 8'hFC means a shift of 4. With `shift_neg`=0 it is used directly.
- R10: A cycle with `in_valid`=1 updates `out_vec` at the next rising clock edge and sets `out_valid` for that cycle. While `in_valid`=0, `out_vec` holds and `out_valid` is 0.
- R11: While `rst_n` is low, `out_vec` is zero and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; acts as the output register's clock enable |
| src_vec | input | 128 | Source vector to be shifted |
| dst_vec | input | 128 | Old destination vector (the accumulate addend) |
| lane_sz | input | 2 | Lane width code (R1) |
| is_signed | input | 1 | 1 selects arithmetic shifting, 0 selects logical |
| accum_en | input | 1 | 1 adds the rounded lanes into `dst_vec` |
| shift_amt | input | 8 | Shift count, 1 to lane width after optional negation |
| shift_neg | input | 1 | 1 means `shift_amt` is a negated count |
| wide_op | input | 1 | 1 selects 128-bit operation, 0 selects 64-bit |
| out_vec | output | 128 | New destination vector |
| out_valid | output | 1 | High for the cycle after an accepted operation |

## Verification
The bench sweeps every lane width at shifts of 1, width minus 1 and width, with lane values at the most negative, most positive, zero and all-ones points. These are the values where a rounding increment can carry out of a lane, or where a full-width shift breaks a naive shifter. A design that lets the rounding or accumulate carry leak into the next lane shows up in the all-ones and wrap-around cases. A design that shifts by the full width directly returns the sign bits or zero instead of 0 or the MSB. A design that skips the upper-half clear, or uses the negative count unconverted, gives visibly wrong upper bits or magnitudes in the directed vectors.

// File: rtl/vrshift_pkg.sv
package vrshift_pkg;
  localparam int VEC_W  = 128;
  localparam int MAX_LW = 64;
  localparam int SH_W   = $clog2(MAX_LW) + 1;
  localparam int AMT_W  = SH_W + 1;
  localparam int N_SZ   = 4;

  typedef enum logic [1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2,
    LSZ_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/vrshift_lane.sv
module vrshift_lane #(
  parameter int W    = 8,
  parameter int SH_W = 7
) (
  input  logic [W-1:0]    src_l,
  input  logic [W-1:0]    dst_l,
  input  logic            is_signed,
  input  logic            accum_en,
  input  logic [SH_W-1:0] shift,
  output logic [W-1:0]    res_l
);
  logic [W:0]      ext;
  logic [SH_W-1:0] pre_sh;
  logic [W-1:0]    partial;
  logic [W-1:0]    rounded;
  logic [W-1:0]    addend;

  always_comb begin
    ext     = {is_signed & src_l[W-1], src_l};
    pre_sh  = shift - SH_W'(1);
    partial = W'($signed(ext) >>> pre_sh);
    rounded = {is_signed & partial[W-1], partial[W-1:1]}
            + {{(W-1){1'b0}}, partial[0]};
    addend  = accum_en ? dst_l : '0;
    res_l   = rounded + addend;
  end
endmodule

// File: rtl/vrshift_bank.sv
module vrshift_bank #(
  parameter int VW   = 128,
  parameter int W    = 8,
  parameter int SH_W = 7
) (
  input  logic [VW-1:0]   src_v,
  input  logic [VW-1:0]   dst_v,
  input  logic            is_signed,
  input  logic            accum_en,
  input  logic [SH_W-1:0] shift,
  output logic [VW-1:0]   res_v
);
  localparam int NL = VW / W;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    vrshift_lane #(.W(W), .SH_W(SH_W)) u_lane (
      .src_l     (src_v[i*W +: W]),
      .dst_l     (dst_v[i*W +: W]),
      .is_signed (is_signed),
      .accum_en  (accum_en),
      .shift     (shift),
      .res_l     (res_v[i*W +: W])
    );
  end
endmodule

// File: rtl/vrshift_acc_unit.sv
module vrshift_acc_unit
  import vrshift_pkg::*;
#(
  parameter int VW    = VEC_W,
  parameter int SHW   = SH_W,
  parameter int AMTW  = AMT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VW-1:0]   src_vec,
  input  logic [VW-1:0]   dst_vec,
  input  logic [1:0]      lane_sz,
  input  logic            is_signed,
  input  logic            accum_en,
  input  logic [AMTW-1:0] shift_amt,
  input  logic            shift_neg,
  input  logic            wide_op,
  output logic [VW-1:0]   out_vec,
  output logic            out_valid
);
  localparam int HW = VW / 2;

  logic [AMTW-1:0] neg_amt;
  logic [SHW-1:0]  eff_shift;
  logic [VW-1:0]   bank_res [N_SZ];
  logic [VW-1:0]   sel_res;
  logic [VW-1:0]   next_vec;
  lane_sz_e        sz;

  always_comb begin
    neg_amt   = ~shift_amt + AMTW'(1);
    eff_shift = shift_neg ? neg_amt[SHW-1:0] : shift_amt[SHW-1:0];
    sz        = lane_sz_e'(lane_sz);
  end

  for (genvar g = 0; g < N_SZ; g++) begin : g_size
    localparam int LW = 8 << g;
    vrshift_bank #(.VW(VW), .W(LW), .SH_W(SHW)) u_bank (
      .src_v     (src_vec),
      .dst_v     (dst_vec),
      .is_signed (is_signed),
      .accum_en  (accum_en),
      .shift     (eff_shift),
      .res_v     (bank_res[g])
    );
  end

  always_comb begin
    case (sz)
      LSZ_8:   sel_res = bank_res[0];
      LSZ_16:  sel_res = bank_res[1];
      LSZ_32:  sel_res = bank_res[2];
      default: sel_res = bank_res[3];
    endcase
    next_vec = sel_res;
    if (!wide_op) next_vec[VW-1:HW] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vec   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= next_vec;
    end
  end

  // R8: narrow operation leaves the upper half clear
  a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide_op |=> out_vec[VW-1:HW] == '0);

  // R5: signed 64-bit lane, full-width shift, no accumulate
  a_r5_signed_full_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_signed && !accum_en && lane_sz == 2'd3 && eff_shift == SHW'(64)
    |=> out_vec[63:0] == 64'd0);

  // R6: unsigned 64-bit lane, full-width shift yields the old MSB
  a_r6_unsigned_full_msb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_signed && !accum_en && lane_sz == 2'd3 && eff_shift == SHW'(64)
    |=> out_vec[63:0] == {63'd0, $past(src_vec[63])});

  // R7: signed full-width accumulate keeps the destination lane
  a_r7_acc_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_signed && accum_en && lane_sz == 2'd3 && eff_shift == SHW'(64)
    |=> out_vec[63:0] == $past(dst_vec[63:0]));

  // R10: result holds while idle, strobe follows the accepted cycle
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec) && !out_valid);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
endmodule

// File: tb/vrshift_acc_unit_test.sv
`timescale 1ns/1ps
module vrshift_acc_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src_vec, dst_vec;
  logic [1:0]   lane_sz;
  logic         is_signed, accum_en, shift_neg, wide_op;
  logic [7:0]   shift_amt;
  logic [127:0] out_vec;
  logic         out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vrshift_acc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_vec(src_vec), .dst_vec(dst_vec), .lane_sz(lane_sz),
    .is_signed(is_signed), .accum_en(accum_en), .shift_amt(shift_amt),
    .shift_neg(shift_neg), .wide_op(wide_op),
    .out_vec(out_vec), .out_valid(out_valid)
  );

  typedef struct packed {
    logic [1:0]   sz;
    logic         sgn;
    logic         acc;
    logic [7:0]   amt;
    logic         neg;
    logic         wide;
    logic [127:0] src;
    logic [127:0] dst;
    logic [127:0] exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VTAB [NV] = '{
    // R2: unsigned 8-bit, 3 >> 1 rounds up to 2
    '{2'd0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b1, {16{8'h03}}, 128'd0, {16{8'h02}}},
    // R3: signed 8-bit, -5 >> 2 rounds to -1
    '{2'd0, 1'b1, 1'b0, 8'd2, 1'b0, 1'b1, {16{8'hFB}}, 128'd0, {16{8'hFF}}},
    // R4/R6: unsigned 16-bit full shift gives 1, added to FFFF wraps to 0
    '{2'd1, 1'b0, 1'b1, 8'd16, 1'b0, 1'b1, {8{16'h8000}}, {8{16'hFFFF}}, 128'd0},
    // R7: signed 64-bit full shift with accumulate keeps destination
    '{2'd3, 1'b1, 1'b1, 8'd64, 1'b0, 1'b1, {2{64'h8000_0000_0000_0000}},
      {2{64'h1234_5678_9ABC_DEF0}}, {2{64'h1234_5678_9ABC_DEF0}}},
    // R9: negated count 8'hFC means 4; 24 -> 2
    '{2'd2, 1'b0, 1'b0, 8'hFC, 1'b1, 1'b1, {4{32'd24}}, 128'd0, {4{32'd2}}},
    // R8: narrow op, unsigned 8-bit full shift of FF gives 1 in the low half only
    '{2'd0, 1'b0, 1'b1, 8'd8, 1'b0, 1'b0, {16{8'hFF}}, {16{8'h00}}, {64'd0, {8{8'h01}}}}
  };

  function automatic logic [127:0] ref_model(logic [127:0] s, logic [127:0] d,
      int w, bit sgn, bit acc, int sh, bit wide);
    logic [127:0] res = '0;
    logic [65:0]  v;
    logic [65:0]  r;
    logic [63:0]  lm, sl, dl, rl;
    lm = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < 128 / w; i++) begin
      sl = 64'(s >> (i * w)) & lm;
      dl = 64'(d >> (i * w)) & lm;
      v  = {2'b00, sl};
      if (sgn && sl[w-1]) v = v | ~{2'b00, lm};
      v  = v + (66'd1 << (sh - 1));
      r  = 66'($signed(v) >>> sh);
      rl = r[63:0];
      if (acc) rl = rl + dl;
      rl = rl & lm;
      res = res | (128'(rl) << (i * w));
    end
    if (!wide) res[127:64] = '0;
    return res;
  endfunction

  function automatic logic [127:0] rep(logic [63:0] lane, int w);
    logic [127:0] o = '0;
    for (int i = 0; i < 128 / w; i++) o = o | (128'(lane) << (i * w));
    return o;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(logic [1:0] sz, bit sgn, bit acc, logic [7:0] amt,
      bit neg, bit wide, logic [127:0] s, logic [127:0] d);
    @(negedge clk);
    lane_sz = sz; is_signed = sgn; accum_en = acc; shift_amt = amt;
    shift_neg = neg; wide_op = wide; src_vec = s; dst_vec = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] hold_val;
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '1; dst_vec = '1;
    lane_sz = 2'd0; is_signed = 1'b0; accum_en = 1'b0;
    shift_amt = 8'd1; shift_neg = 1'b0; wide_op = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_vec", out_vec, 128'd0);
    check("R11 out_valid", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;

    // table of directed vectors
    for (int k = 0; k < NV; k++) begin
      run_op(VTAB[k].sz, VTAB[k].sgn, VTAB[k].acc, VTAB[k].amt,
             VTAB[k].neg, VTAB[k].wide, VTAB[k].src, VTAB[k].dst);
      check($sformatf("R2-vector%0d", k), out_vec, VTAB[k].exp);
    end

    // R10: output valid after one cycle, hold while idle
    check("R10 out_valid", {127'd0, out_valid}, 128'd1);
    hold_val = out_vec;
    @(negedge clk);
    src_vec = ~src_vec; dst_vec = 128'h5;
    @(negedge clk);
    check("R10 hold", out_vec, hold_val);
    check("R10 valid low", {127'd0, out_valid}, 128'd0);

    // R1..R8 sweep: each lane width, signedness, mode, corner shifts and values
    for (int z = 0; z < 4; z++) begin
      int w;
      w = 8 << z;
      for (int sg = 0; sg < 2; sg++)
        for (int ac = 0; ac < 2; ac++)
          for (int sc = 0; sc < 3; sc++)
            for (int p = 0; p < 5; p++) begin
              int sh;
              logic [63:0]  lane;
              logic [127:0] s, d, e;
              sh = (sc == 0) ? 1 : ((sc == 1) ? w - 1 : w);
              case (p)
                0: lane = 64'd1 << (w - 1);
                1: lane = (64'd1 << (w - 1)) - 64'd1;
                2: lane = 64'd0;
                3: lane = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
                default: lane = 64'h0;
              endcase
              s = (p == 4) ? 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
                           : rep(lane, w);
              d = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
              e = ref_model(s, d, w, sg[0], ac[0], sh, 1'b1);
              run_op(2'(z), sg[0], ac[0], 8'(sh), 1'b0, 1'b1, s, d);
              check($sformatf("R1/R4 w=%0d s=%0d acc=%0d sh=%0d p=%0d",
                    w, sg, ac, sh, p), out_vec, e);
            end
    end

    // R9: negated count on signed 16-bit lanes, narrow op (R8)
    begin
      logic [127:0] s, e;
      s = 128'hFFFF_8000_7FFF_0001_ABCD_1234_FFF7_0009;
      e = ref_model(s, 128'd0, 16, 1'b1, 1'b0, 3, 1'b0);
      run_op(2'd1, 1'b1, 1'b0, 8'hFD, 1'b1, 1'b0, s, 128'd0);
      check("R9 neg count narrow", out_vec, e);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule